// File: doc/BRIEF.md
# SD Command Path Engine

This block issues one SD/MMC command on the single-bit command line and collects the card's reply. Software presents a 6-bit command index, a 32-bit argument, a reply kind and a wait limit, then pulses `start`. The engine builds a 48-bit command token. The CRC7 check field is computed bit by bit while the token leaves the engine, so the CRC costs no separate pass. The engine then watches the command line for the card's start bit and captures either a 48-bit or a 136-bit reply. It finishes with exactly one of three results: reply ready, reply timeout or reply CRC error.

Every accepted command inverts a toggle bit. When a command completes, the toggle value of that command is copied into the status. Software can therefore tell whether the flags it reads belong to the command it last issued. While a command is in flight, a new `start` is refused: the engine raises a busy pulse and changes nothing on the bus. A deselect command (index 7 with argument 0) never waits for a reply. For the 48-bit reply with busy signalling, completion is held back until the card releases data line 0.

The engine runs directly on the card clock and sends or samples one bit per cycle. It has no data-line transfer logic and no block buffer.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted start drives `cmdOe` high for exactly 48 cycles, starting the cycle after the start edge. The token goes out MSB first, one bit per cycle, in this order: a 0 bit, a 1 bit, the 6-bit index, then the 32-bit argument with its most significant bit first.
- R2: Token bits 7..1 carry a CRC7 over the first 40 token bits. The CRC uses the generator x^7+x^3+1 (feedback mask 0x09), a zero start value and MSB-first order. Token bit 0 is the end bit and is 1. Index 0 with argument 0 therefore ends in the byte 0x95.
- R3: A `start` while `idle` is low has no effect. `startRefused` is high in the following cycle. The running token, its outcome and `cmdToggle` are all unchanged.
- R4: `cmdToggle` resets to 0 and inverts on every accepted start. At completion, `statToggle` takes the `cmdToggle` value of the command that completed.
- R5: With `rspType` = 0 (no reply), `idle` and `rspReady` are high in the cycle after the last token bit. That is 48 cycles after the cycle in which `start` was applied.
- R6: Index 7 with argument 0 completes exactly as R5, whatever value `rspType` holds.
- R7: After the token, `cmdIn` is sampled once per cycle, starting at sample 0. A 0 seen at sample k is taken as the reply start bit if k ≤ `waitLimit` (12 bits, 0xFFF is the longest wait). If no 0 is seen, the command ends with `rspTimeout` at sample `waitLimit`, and `idle` is high 49+`waitLimit` cycles after the start cycle.
- R8: With `rspType` 1 (48-bit) or 2 (48-bit with busy), 48 bits are captured. Results appear two cycles after the last reply bit is sampled. `rspData[39:0]` holds the first 40 received bits (start bit at bit 39) and the upper bits are 0.
- R9: With `rspType` 3, 136 bits are captured. `rspData[127:0]` holds the first 128 received bits, with the CRC and end bit removed.
- R10: For 48-bit replies with `rspNoCrc` low, the received bits 7..1 must equal the CRC7 of the first 40 received bits, and the last bit must be 1. Otherwise the command ends with `rspCrcErr` and not `rspReady`. With `rspNoCrc` high, the CRC is not checked.
- R11: With `rspType` 2 and a valid reply, completion waits while `dat0In` is low. `idle` and `rspReady` rise one cycle after `dat0In` is first sampled high.
- R12: During and after reset: `idle` is 1, `cmdOe` is 0, `cmdOut` is 1, all flags are 0, both toggles are 0 and `rspData` is 0.
- R13: At most one of `rspReady`, `rspTimeout` and `rspCrcErr` is high at any time. All three are low in the cycle after an accepted start, and a set flag holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one bus bit per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to issue a command |
| cmdIdx | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| rspType | input | 2 | Reply kind: 0 none, 1 48-bit, 2 48-bit with busy, 3 136-bit |
| rspNoCrc | input | 1 | Skip the CRC check on a 48-bit reply |
| waitLimit | input | 12 | Last sample index at which a reply start bit is accepted |
| cmdIn | input | 1 | Command line as seen from the card side |
| dat0In | input | 1 | Data line 0, low while the card is busy |
| cmdOut | output | 1 | Command line drive value, 1 when not driving |
| cmdOe | output | 1 | Command line drive enable |
| idle | output | 1 | Engine ready to accept a start |
| startRefused | output | 1 | Pulse: the previous cycle's start was refused |
| cmdToggle | output | 1 | Toggle of the most recently accepted command |
| statToggle | output | 1 | Toggle of the command whose flags are shown |
| rspReady | output | 1 | Command completed successfully |
| rspTimeout | output | 1 | No reply start bit within the wait limit |
| rspCrcErr | output | 1 | 48-bit reply failed its CRC or end-bit check |
| rspData | output | 128 | Captured reply with CRC and end bit removed |

## Verification
Each result is due a fixed number of cycles after a known event. The token occupies the 48 cycles right after the start edge. A no-reply completion shows one cycle after the token. A timeout shows 49+`waitLimit` cycles after the start. A captured reply resolves two cycles after its last bit is sampled. A busy hold ends one cycle after `dat0In` is seen high. The bench counts falling edges from the start edge and records the first edge on which `idle` is high, then compares that count with the figure derived from these rules. It also checks the token bits, flags, toggle and captured data at the same falling edges. The wait limit is exercised on both sides of its boundary, and the refused start is inserted in the middle of a token.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_SHORT      = 2'd1,
    RSP_SHORT_BUSY = 2'd2,
    RSP_LONG       = 2'd3
  } rspKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic txStep;
    logic waitClr;
    logic waitStep;
    logic rxStart;
    logic rxStep;
    logic longFrame;
  } dpCtl_t;

  // conditions reported back to control
  typedef struct packed {
    logic txLast;
    logic waitExpired;
    logic rxLast;
    logic crcMatch;
  } dpStat_t;

  // one serial CRC7 step, most significant bit first
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/sd_cmd_dp.sv
module sd_cmd_dp
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int TO_W      = 12,
  parameter int LONG_BITS = 136
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtl_t                         ctl,
  input  logic [IDX_W-1:0]               idx,
  input  logic [ARG_W-1:0]               arg,
  input  logic [TO_W-1:0]                waitLimit,
  input  logic                           cmdIn,
  output logic                           txBit,
  output dpStat_t                        stat,
  output logic [LONG_BITS-CRC_W-2:0]     rspData
);

  localparam int HDR_BITS = 2 + IDX_W + ARG_W;
  localparam int TOK_BITS = HDR_BITS + CRC_W + 1;
  localparam int CNT_W    = $clog2(LONG_BITS + 1);
  localparam logic [CNT_W-1:0] HDR_END   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] TOK_LAST  = CNT_W'(TOK_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_BITS - 1);

  logic [HDR_BITS-1:0]  hdr;
  logic [CRC_W-1:0]     crc;
  logic [CNT_W-1:0]     bitCnt;
  logic [TO_W-1:0]      waitCnt;
  logic [TO_W-1:0]      limit;
  logic [LONG_BITS-1:0] rx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr     <= '0;
      crc     <= '0;
      bitCnt  <= '0;
      limit   <= '0;
      rx      <= '0;
      waitCnt <= '0;
    end else begin
      if (ctl.load) begin
        hdr    <= {2'b01, idx, arg};
        crc    <= '0;
        bitCnt <= '0;
        limit  <= waitLimit;
      end else if (ctl.txStep) begin
        if (bitCnt < HDR_END) begin
          crc <= crcStep(crc, hdr[HDR_BITS-1]);
          hdr <= {hdr[HDR_BITS-2:0], 1'b0};
        end else begin
          crc <= {crc[CRC_W-2:0], 1'b0};
        end
        bitCnt <= bitCnt + 1'b1;
      end else if (ctl.rxStart) begin
        // the start bit itself is a zero, which leaves a zero CRC unchanged
        rx     <= '0;
        crc    <= '0;
        bitCnt <= CNT_W'(1);
      end else if (ctl.rxStep) begin
        rx <= {rx[LONG_BITS-2:0], cmdIn};
        if (bitCnt < HDR_END) crc <= crcStep(crc, cmdIn);
        bitCnt <= bitCnt + 1'b1;
      end

      if (ctl.waitClr)       waitCnt <= '0;
      else if (ctl.waitStep) waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    if (bitCnt < HDR_END)       txBit = hdr[HDR_BITS-1];
    else if (bitCnt < TOK_LAST) txBit = crc[CRC_W-1];
    else                        txBit = 1'b1;
  end

  assign stat.txLast      = (bitCnt == TOK_LAST);
  assign stat.waitExpired = (waitCnt == limit);
  assign stat.rxLast      = (bitCnt == (ctl.longFrame ? LONG_LAST : TOK_LAST));
  assign stat.crcMatch    = (rx[CRC_W:1] == crc) && rx[0];
  assign rspData          = rx[LONG_BITS-1:CRC_W+1];

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  input  logic [1:0]       rspType,
  input  logic             rspNoCrc,
  input  logic             cmdIn,
  input  logic             dat0In,
  input  dpStat_t          stat,
  output dpCtl_t           ctl,
  output logic             cmdOe,
  output logic             idle,
  output logic             startRefused,
  output logic             cmdToggle,
  output logic             statToggle,
  output logic             rspReady,
  output logic             rspTimeout,
  output logic             rspCrcErr
);

  localparam logic [IDX_W-1:0] DESELECT_IDX = IDX_W'(7);

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_WAIT, S_RECV, S_CHECK, S_HOLD
  } state_e;

  state_e   state, stateNx;
  rspKind_e kind;
  logic     skipCrc, noReply;
  logic     finOk, finTo, finCrc;

  always_comb begin
    ctl           = '0;
    ctl.longFrame = (kind == RSP_LONG);
    stateNx       = state;
    finOk         = 1'b0;
    finTo         = 1'b0;
    finCrc        = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateNx  = S_SEND;
        end
      end
      S_SEND: begin
        ctl.txStep = 1'b1;
        if (stat.txLast) begin
          if (noReply) begin
            finOk   = 1'b1;
            stateNx = S_IDLE;
          end else begin
            ctl.waitClr = 1'b1;
            stateNx     = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (!cmdIn) begin
          ctl.rxStart = 1'b1;
          stateNx     = S_RECV;
        end else if (stat.waitExpired) begin
          finTo   = 1'b1;
          stateNx = S_IDLE;
        end else begin
          ctl.waitStep = 1'b1;
        end
      end
      S_RECV: begin
        ctl.rxStep = 1'b1;
        if (stat.rxLast) stateNx = S_CHECK;
      end
      S_CHECK: begin
        if (kind != RSP_LONG && !skipCrc && !stat.crcMatch) begin
          finCrc  = 1'b1;
          stateNx = S_IDLE;
        end else if (kind == RSP_SHORT_BUSY) begin
          stateNx = S_HOLD;
        end else begin
          finOk   = 1'b1;
          stateNx = S_IDLE;
        end
      end
      S_HOLD: begin
        if (dat0In) begin
          finOk   = 1'b1;
          stateNx = S_IDLE;
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      kind         <= RSP_NONE;
      skipCrc      <= 1'b0;
      noReply      <= 1'b0;
      cmdToggle    <= 1'b0;
      statToggle   <= 1'b0;
      startRefused <= 1'b0;
      rspReady     <= 1'b0;
      rspTimeout   <= 1'b0;
      rspCrcErr    <= 1'b0;
    end else begin
      state        <= stateNx;
      startRefused <= start && (state != S_IDLE);
      if (state == S_IDLE && start) begin
        kind       <= rspKind_e'(rspType);
        skipCrc    <= rspNoCrc;
        noReply    <= (rspType == RSP_NONE) || (idx == DESELECT_IDX && arg == '0);
        cmdToggle  <= ~cmdToggle;
        rspReady   <= 1'b0;
        rspTimeout <= 1'b0;
        rspCrcErr  <= 1'b0;
      end
      if (finOk || finTo || finCrc) statToggle <= cmdToggle;
      if (finOk)  rspReady   <= 1'b1;
      if (finTo)  rspTimeout <= 1'b1;
      if (finCrc) rspCrcErr  <= 1'b1;
    end
  end

  assign cmdOe = (state == S_SEND);
  assign idle  = (state == S_IDLE);

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int TO_W      = 12,
  parameter int LONG_BITS = 136,
  localparam int RSP_W    = LONG_BITS - CRC_W - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic [ARG_W-1:0] cmdArg,
  input  logic [1:0]       rspType,
  input  logic             rspNoCrc,
  input  logic [TO_W-1:0]  waitLimit,
  input  logic             cmdIn,
  input  logic             dat0In,
  output logic             cmdOut,
  output logic             cmdOe,
  output logic             idle,
  output logic             startRefused,
  output logic             cmdToggle,
  output logic             statToggle,
  output logic             rspReady,
  output logic             rspTimeout,
  output logic             rspCrcErr,
  output logic [RSP_W-1:0] rspData
);

  dpCtl_t  ctl;
  dpStat_t stat;
  logic    txBit;

  sd_cmd_ctrl #(.IDX_W(IDX_W), .ARG_W(ARG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .idx(cmdIdx), .arg(cmdArg),
    .rspType(rspType), .rspNoCrc(rspNoCrc), .cmdIn(cmdIn), .dat0In(dat0In),
    .stat(stat), .ctl(ctl), .cmdOe(cmdOe), .idle(idle),
    .startRefused(startRefused), .cmdToggle(cmdToggle), .statToggle(statToggle),
    .rspReady(rspReady), .rspTimeout(rspTimeout), .rspCrcErr(rspCrcErr)
  );

  sd_cmd_dp #(.IDX_W(IDX_W), .ARG_W(ARG_W), .TO_W(TO_W), .LONG_BITS(LONG_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(cmdIdx), .arg(cmdArg),
    .waitLimit(waitLimit), .cmdIn(cmdIn), .txBit(txBit), .stat(stat),
    .rspData(rspData)
  );

  assign cmdOut = cmdOe ? txBit : 1'b1;

endmodule

// File: rtl/sd_cmd_checker.sv
module sd_cmd_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic idle,
  input logic cmdOe,
  input logic cmdOut,
  input logic startRefused,
  input logic cmdToggle,
  input logic statToggle,
  input logic rspReady,
  input logic rspTimeout,
  input logic rspCrcErr
);

  a_r13_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspReady, rspTimeout, rspCrcErr}));

  a_r13_flags_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (start && idle) |=> (!rspReady && !rspTimeout && !rspCrcErr));

  a_r3_refused_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (start && !idle) |=> startRefused);

  a_r3_toggle_kept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !idle) |=> $stable(cmdToggle));

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (start && idle) |=> (cmdToggle != $past(cmdToggle)));

  a_r4_status_echo: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> (statToggle == cmdToggle));

  a_r1_drive_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdOe |-> !idle);

  a_r2_end_bit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdOe) |-> $past(cmdOut));

endmodule

bind sd_cmd_engine sd_cmd_checker i_chk (
  .clk(clk), .rstN(rstN), .start(start), .idle(idle), .cmdOe(cmdOe),
  .cmdOut(cmdOut), .startRefused(startRefused), .cmdToggle(cmdToggle),
  .statToggle(statToggle), .rspReady(rspReady), .rspTimeout(rspTimeout),
  .rspCrcErr(rspCrcErr)
);

// File: tb/test_sd_cmd_engine.sv
`timescale 1ns/1ps
module test_sd_cmd_engine;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   cmdIdx = '0;
  logic [31:0]  cmdArg = '0;
  logic [1:0]   rspType = '0;
  logic         rspNoCrc = 1'b0;
  logic [11:0]  waitLimit = 12'hFFF;
  logic         cmdIn = 1'b1;
  logic         dat0In = 1'b1;
  logic         cmdOut, cmdOe, idle, startRefused, cmdToggle, statToggle;
  logic         rspReady, rspTimeout, rspCrcErr;
  logic [127:0] rspData;

  int   nChecks = 0;
  int   nFail = 0;
  int   n;
  int   firstIdle;
  logic expToggle = 1'b0;
  logic [7:0] lastByte;

  always #2 clk = ~clk;

  sd_cmd_engine i_sd_cmd_engine (.*);

  // stimulus table: one command per entry
  localparam int NV = 8;
  localparam logic [5:0]  V_IDX   [NV] = '{6'd0, 6'd8, 6'd2, 6'd7, 6'd17, 6'd41, 6'd55, 6'd12};
  localparam logic [31:0] V_ARG   [NV] = '{32'h0, 32'h1AA, 32'h0, 32'h0, 32'h12345678,
                                           32'h40FF8000, 32'hABCD0000, 32'h0};
  localparam logic [1:0]  V_TYPE  [NV] = '{2'd0, 2'd1, 2'd3, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2};
  localparam logic        V_NOCRC [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [11:0] V_LIM   [NV] = '{12'd100, 12'd100, 12'd100, 12'd100, 12'd100,
                                           12'd100, 12'd30, 12'd100};
  localparam int          V_DELAY [NV] = '{-1, 2, 5, -1, 0, 4, -1, 3};
  localparam logic        V_CORR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int          V_BUSY  [NV] = '{0, 0, 0, 0, 0, 0, 0, 10};
  localparam int          V_EXP   [NV] = '{0, 0, 0, 0, 2, 0, 1, 0};  // 0 ready, 1 timeout, 2 crc

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic tick();
    @(negedge clk);
    n++;
    if (n >= 0 && idle && firstIdle < 0) firstIdle = n;
  endtask

  task automatic runCmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rtype,
                        input logic noCrc, input logic [11:0] lim, input int delay,
                        input logic corrupt, input int busyHold, input int outcome,
                        input int injectAt);
    logic [47:0]  tok, expTok;
    logic [135:0] frame;
    logic [127:0] expData;
    logic [39:0]  pay;
    logic [127:0] lpay;
    logic         oeOk, noReply;
    int flen, expIdle, nLast;
    string idleTag, dataTag;

    @(negedge clk);
    cmdIdx = idx; cmdArg = arg; rspType = rtype; rspNoCrc = noCrc; waitLimit = lim;
    start = 1'b1;
    n = -1;
    firstIdle = -1;
    expToggle = ~expToggle;
    tick();                       // n = 0: first token bit on the line
    start = 1'b0;
    check(!rspReady && !rspTimeout && !rspCrcErr, "R13 flags cleared after start",
          {rspReady, rspTimeout, rspCrcErr}, 0);
    check(cmdToggle == expToggle, "R4 toggle flips", cmdToggle, expToggle);

    oeOk = 1'b1;
    for (int k = 0; k < 48; k++) begin
      if (k > 0) tick();
      oeOk = oeOk & cmdOe;
      tok[47-k] = cmdOut;
      if (k == injectAt) begin
        start = 1'b1;
        cmdIdx = ~idx;
      end
      if (injectAt >= 0 && k == injectAt + 1) begin
        check(startRefused, "R3 busy start refused", startRefused, 1);
        start = 1'b0;
      end
    end
    tick();                       // n = 48
    check(oeOk && !cmdOe, "R1 drive window 48 cycles", {oeOk, cmdOe}, 2'b10);
    expTok = {2'b01, idx, arg, refCrc({2'b01, idx, arg}), 1'b1};
    check(tok[47:8] == expTok[47:8], "R1 token header", tok, expTok);
    check(tok[7:0] == expTok[7:0], "R2 token crc byte", tok[7:0], expTok[7:0]);
    lastByte = tok[7:0];

    noReply = (rtype == 2'd0) || (idx == 6'd7 && arg == 32'h0);
    pay  = {2'b00, idx, arg ^ 32'h0000_0900};
    lpay = {8'h3F, arg, ~arg, arg, arg[31:8]};
    expData = '0;
    nLast = 0;
    idleTag = (rtype == 2'd2) ? "R11 busy release timing" : "R8 reply completion timing";
    dataTag = (rtype == 2'd3) ? "R9 long reply data" : "R8 short reply data";
    if (noReply) begin
      expIdle = 48;
      idleTag = (rtype != 2'd0) ? "R6 deselect completion timing" : "R5 no-reply completion timing";
    end else if (delay < 0 || delay > int'(lim)) begin
      expIdle = 49 + int'(lim);
      idleTag = "R7 timeout timing";
    end else begin
      expIdle = 0;
    end

    if (!noReply && delay >= 0) begin
      if (rtype == 2'd3) begin
        frame = {lpay, 7'h5A, 1'b1};
        flen = 136;
        expData = lpay;
      end else begin
        frame = {88'h0, pay, refCrc(pay) ^ {6'b0, corrupt}, 1'b1};
        flen = 48;
        expData = {88'h0, pay};
      end
      repeat (delay) tick();
      for (int j = 0; j < flen; j++) begin
        if (j > 0) tick();
        cmdIn = frame[flen-1-j];
        if (j == 0 && rtype == 2'd2) dat0In = 1'b0;
      end
      nLast = n;
      tick();
      cmdIn = 1'b1;
      if (expIdle == 0) begin
        if (rtype == 2'd2 && outcome == 0) begin
          repeat (busyHold - 1) tick();
          check(!idle, "R11 completion held while busy", idle, 0);
          dat0In = 1'b1;
          expIdle = n + 1;
        end else begin
          expIdle = nLast + 2;
        end
      end
    end

    for (int w = 0; w < 6000 && !idle; w++) tick();
    tick();
    dat0In = 1'b1;
    if (outcome == 2) idleTag = "R10 crc error timing";
    check(firstIdle == expIdle, idleTag, firstIdle, expIdle);
    case (outcome)
      0: check(rspReady && !rspTimeout && !rspCrcErr,
               noCrc ? "R10 crc check skipped" : "R13 ready flag only",
               {rspReady, rspTimeout, rspCrcErr}, 3'b100);
      1: check(!rspReady && rspTimeout && !rspCrcErr, "R7 timeout flag",
               {rspReady, rspTimeout, rspCrcErr}, 3'b010);
      default: check(!rspReady && !rspTimeout && rspCrcErr, "R10 crc error flag",
               {rspReady, rspTimeout, rspCrcErr}, 3'b001);
    endcase
    check(statToggle == expToggle, "R4 status toggle echo", statToggle, expToggle);
    if (outcome == 0 && !noReply) check(rspData == expData, dataTag, rspData, expData);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(idle && !cmdOe && cmdOut, "R12 reset line state", {idle, cmdOe, cmdOut}, 3'b101);
    check(!rspReady && !rspTimeout && !rspCrcErr && !startRefused, "R12 reset flags",
          {rspReady, rspTimeout, rspCrcErr, startRefused}, 0);
    check(!cmdToggle && !statToggle && rspData == '0, "R12 reset toggles and data",
          {cmdToggle, statToggle, rspData}, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(idle && !cmdOe && cmdOut, "R12 after reset release", {idle, cmdOe, cmdOut}, 3'b101);

    for (int v = 0; v < NV; v++) begin
      runCmd(V_IDX[v], V_ARG[v], V_TYPE[v], V_NOCRC[v], V_LIM[v], V_DELAY[v],
             V_CORR[v], V_BUSY[v], V_EXP[v], -1);
      if (v == 0) check(lastByte == 8'h95, "R2 index 0 final byte", lastByte, 8'h95);
    end

    // R7 boundary: start bit on the last allowed sample, then one sample late
    runCmd(6'd13, 32'h0001_0000, 2'd1, 1'b0, 12'd10, 10, 1'b0, 0, 0, -1);
    runCmd(6'd13, 32'h0001_0000, 2'd1, 1'b0, 12'd10, 11, 1'b0, 0, 1, -1);
    // R7 shortest wait limit
    runCmd(6'd9, 32'hFFFF_FFFF, 2'd3, 1'b0, 12'd0, 0, 1'b0, 0, 0, -1);
    // R3 start mid-token is refused and leaves the command intact
    runCmd(6'd16, 32'h0000_0200, 2'd1, 1'b0, 12'd50, 1, 1'b0, 0, 0, 5);
    // R6 deselect with busy reply kind still needs no reply
    runCmd(6'd7, 32'h0, 2'd2, 1'b0, 12'd50, -1, 1'b0, 0, 0, -1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule